// File: doc/BRIEF.md
# UART In-Band Flow Control Unit

This block carries the XON/XOFF side of flow control for one serial channel. It sits between the character decoder of the receiver and the character encoder of the transmitter. Each received character is compared with three programmable codes: the stop code, the resume code and the special code. A stop code halts the local transmitter through a gate output. A resume code releases the gate. Flow codes are never passed on to the receive buffer. When a special code is stored, a sticky flag is raised so that software can tell that interrupt cause apart from a stop code.

On the transmit side, a throttle trigger from the receive-buffer level logic asks the transmitter to slip a stop code into the outgoing stream. The request is held until the transmitter acknowledges it at a character boundary. Software releases the far end by writing 0 to the remote-halted status bit, which queues a resume code. An 8-bit status register gathers these flags together with the modem-control states and transmitter idleness. A receiver-disable control stops characters from being stored, and a change to it only takes effect between characters.

Top module: `ibfc_unit`

## Requirements
- R1: A received character equal to `xoff_char` sets status bit 0 one cycle later, and `tx_gate` is low while bit 0 is set. A received character equal to `xon_char` clears bit 0.
- R2: A status write with data bit 0 = 0 clears bit 0, and a write with data bit 0 = 1 leaves it unchanged. A received stop code in the same cycle as the clearing write wins, so bit 0 ends up set.
- R3: A `xoff_trig` pulse while bit 1 is clear raises `ins_req` with `ins_xon` = 0 on the next cycle. The request is held until `ins_ack`, and the acknowledge sets bit 1. While bit 1 is set and nothing is pending, `xoff_trig` is ignored.
- R4: A status write with data bit 1 = 0 while bit 1 is set raises `ins_req` with `ins_xon` = 1, and its acknowledge clears bit 1. Writing 1 to bit 1, or writing 0 while bit 1 is clear, requests nothing.
- R5: Hardware reset (`rst_n` low) and the channel reset pulse `sw_rst` clear bits 0, 1 and 4 and drop any pending insertion request.
- R6: With `loopback` low, bits 2 and 3 read `~rts_n` and `~dtr_n`. With `loopback` high, they read `rts_flow` and `dtr_flow`.
- R7: Storing a character equal to `spec_char` sets bit 4. A read strobe clears bit 4 on the following cycle, unless a set event happens in the same cycle as the read, in which case bit 4 stays 1.
- R8: Bit 7 reads 1 exactly when `txf_empty` and `txs_empty` are both 1.
- R9: Bits 5 and 6 read 0, and writes never change bits 7 to 2.
- R10: While the receiver is disabled, `rx_store` stays low and bit 4 is not set, but stop and resume codes still act on bit 0.
- R11: A change of `rx_dis_req` takes effect only in a cycle where `rx_busy` is low. A character that completes while the change is still waiting is handled under the previous setting.
- R12: `rx_store` is high in the cycle of `rx_valid` for every character that is neither the stop code nor the resume code, provided the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Channel reset pulse |
| xon_char | input | 8 | Resume code |
| xoff_char | input | 8 | Stop code |
| spec_char | input | 8 | Special code |
| rx_dis_req | input | 1 | Receiver-disable control bit |
| rx_busy | input | 1 | A character is being received |
| rx_valid | input | 1 | Received character is complete this cycle |
| rx_char | input | 8 | Received character |
| rx_store | output | 1 | Write the character into the receive buffer |
| xoff_trig | input | 1 | Pulse: throttle the remote end |
| ins_req | output | 1 | Request to insert a flow code |
| ins_xon | output | 1 | Code to insert: 1 resume, 0 stop |
| ins_ack | input | 1 | Transmitter took the inserted code |
| tx_gate | output | 1 | Local transmitter may send data |
| txf_empty | input | 1 | Transmit FIFO empty |
| txs_empty | input | 1 | Transmit shift register empty |
| rts_n | input | 1 | RTS pin state, active low |
| dtr_n | input | 1 | DTR pin state, active low |
| rts_flow | input | 1 | RTS flow status used in loopback |
| dtr_flow | input | 1 | DTR flow status used in loopback |
| loopback | input | 1 | Loopback mode |
| st_rd | input | 1 | Status read strobe |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data |
| st_rdata | output | 8 | Status read data |

## Verification
A stuck local-halt flag shows up at once on `tx_gate` and on read bit 0, one cycle after the offending character or write. A lost or duplicated insertion request appears on `ins_req` on the cycle after the trigger or the acknowledge, and a wrong remote-halted state shows through the request that is or is not raised when software writes 0 to bit 1. A wrongly applied receiver-disable becomes visible on `rx_store` in the same cycle as the next completed character. A missed read-clear or set-collision on bit 4 can be seen on the first read after the event.

// File: rtl/ibfc_pkg.sv
// Package: shared bit positions and types for the in-band flow control unit.
// Assumes an 8-bit status register; the positions of the bits are part of the
// software-visible behaviour and must not move.
package ibfc_pkg;
    localparam int ST_W      = 8;
    localparam int ST_TXOFF  = 0;  // local transmitter halted by stop code
    localparam int ST_RMTOFF = 1;  // remote end halted by our stop code
    localparam int ST_RTS    = 2;
    localparam int ST_DTR    = 3;
    localparam int ST_SPEC   = 4;  // special code stored
    localparam int ST_TXIDLE = 7;

    localparam int NCMP    = 3;    // number of code comparators
    localparam int CMP_XON = 0;
    localparam int CMP_XOF = 1;
    localparam int CMP_SPC = 2;

    typedef enum logic {
        INS_STOP   = 1'b0,
        INS_RESUME = 1'b1
    } ins_kind_e;
endpackage

// File: rtl/ibfc_rx_watch.sv
// Receive watcher: compares each completed character with the programmed
// codes, decides whether it is stored, and applies the receiver-disable
// control at character boundaries only (when rx_busy is low).
// Assumes rx_valid marks the last cycle of a character, one cycle wide.
module ibfc_rx_watch
    import ibfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis_req,
    input  logic              busy,
    input  logic              valid,
    input  logic [CHAR_W-1:0] char_in,
    input  logic [CHAR_W-1:0] code_xon,
    input  logic [CHAR_W-1:0] code_xoff,
    input  logic [CHAR_W-1:0] code_spec,
    output logic              dis_eff,
    output logic              hit_xon,
    output logic              hit_xoff,
    output logic              hit_spec,
    output logic              store
);
    logic [CHAR_W-1:0] codes [NCMP];
    logic [NCMP-1:0]   match;
    logic              is_flow;

    assign codes[CMP_XON] = code_xon;
    assign codes[CMP_XOF] = code_xoff;
    assign codes[CMP_SPC] = code_spec;

    // One equality comparator per programmed code.
    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign match[g] = valid && (char_in == codes[g]);
    end

    // Stop code has priority if both flow codes are programmed equal.
    assign hit_xoff = match[CMP_XOF];
    assign hit_xon  = match[CMP_XON] && !match[CMP_XOF];
    assign is_flow  = match[CMP_XOF] || match[CMP_XON];

    // Flow codes are never stored; others only while the receiver is enabled.
    assign store    = valid && !dis_eff && !is_flow;
    assign hit_spec = store && match[CMP_SPC];

    // Take over the disable request only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)      dis_eff <= 1'b0;
        else if (!busy)  dis_eff <= dis_req;
    end
endmodule

// File: rtl/ibfc_ins_ctl.sv
// Insertion controller: holds one pending request to slip a stop or resume
// code into the transmit stream until the transmitter acknowledges it, and
// reports which code was sent. Assumes ins_ack is only meaningful while a
// request is shown.
module ibfc_ins_ctl
    import ibfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic xoff_trig,
    input  logic xon_cmd,
    input  logic rmt_off,
    input  logic ack,
    output logic req,
    output logic req_xon,
    output logic sent_xoff,
    output logic sent_xon
);
    logic      pend;
    ins_kind_e kind;
    logic      take_stop;

    // A stop request is accepted unless the remote is already halted with
    // nothing pending; it overrides a pending resume.
    assign take_stop = xoff_trig && (!rmt_off || (pend && kind == INS_RESUME));

    assign req       = pend;
    assign req_xon   = (kind == INS_RESUME);
    assign sent_xoff = ack && pend && (kind == INS_STOP);
    assign sent_xon  = ack && pend && (kind == INS_RESUME);

    // Pending request register: acknowledge first, new requests after.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            pend <= 1'b0;
            kind <= INS_STOP;
        end else begin
            if (ack && pend) pend <= 1'b0;
            if (take_stop) begin
                pend <= 1'b1;
                kind <= INS_STOP;
            end else if (xon_cmd) begin
                pend <= 1'b1;
                kind <= INS_RESUME;
            end
        end
    end
endmodule

// File: rtl/ibfc_status.sv
// Status register: three sticky bits (local halt, remote halt, special code)
// plus read-only views of modem control and transmitter idleness.
// Assumes rd and wr are single-cycle strobes; read data is combinational.
module ibfc_status
    import ibfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_rst,
    input  logic            hit_xoff,
    input  logic            hit_xon,
    input  logic            hit_spec,
    input  logic            sent_xoff,
    input  logic            sent_xon,
    input  logic            rd,
    input  logic            wr,
    input  logic [ST_W-1:0] wdata,
    input  logic            rts_n,
    input  logic            dtr_n,
    input  logic            rts_flow,
    input  logic            dtr_flow,
    input  logic            loopback,
    input  logic            txf_empty,
    input  logic            txs_empty,
    output logic [ST_W-1:0] rdata,
    output logic            txoff,
    output logic            rmt_off,
    output logic            xon_cmd
);
    logic spec_flag;

    // Writing 0 to the remote-halt bit while it is set asks for a resume code.
    assign xon_cmd = wr && !wdata[ST_RMTOFF] && rmt_off;

    // Local halt: received stop wins over resume and over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)            txoff <= 1'b0;
        else if (hit_xoff)               txoff <= 1'b1;
        else if (hit_xon)                txoff <= 1'b0;
        else if (wr && !wdata[ST_TXOFF]) txoff <= 1'b0;
    end

    // Remote halt: follows the codes actually handed to the transmitter.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) rmt_off <= 1'b0;
        else if (sent_xoff)   rmt_off <= 1'b1;
        else if (sent_xon)    rmt_off <= 1'b0;
    end

    // Special-code flag: a set in the read cycle beats the read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) spec_flag <= 1'b0;
        else if (hit_spec)    spec_flag <= 1'b1;
        else if (rd)          spec_flag <= 1'b0;
    end

    // Read data assembly.
    always_comb begin
        rdata            = '0;
        rdata[ST_TXOFF]  = txoff;
        rdata[ST_RMTOFF] = rmt_off;
        rdata[ST_RTS]    = loopback ? rts_flow : !rts_n;
        rdata[ST_DTR]    = loopback ? dtr_flow : !dtr_n;
        rdata[ST_SPEC]   = spec_flag;
        rdata[ST_TXIDLE] = txf_empty && txs_empty;
    end
endmodule

// File: rtl/ibfc_unit.sv
// Top of the in-band flow control unit for one serial channel: wires the
// receive watcher, the insertion controller and the status register.
// Assumes all inputs are synchronous to clk.
module ibfc_unit
    import ibfc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              rx_dis_req,
    input  logic              rx_busy,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_store,
    input  logic              xoff_trig,
    output logic              ins_req,
    output logic              ins_xon,
    input  logic              ins_ack,
    output logic              tx_gate,
    input  logic              txf_empty,
    input  logic              txs_empty,
    input  logic              rts_n,
    input  logic              dtr_n,
    input  logic              rts_flow,
    input  logic              dtr_flow,
    input  logic              loopback,
    input  logic              st_rd,
    input  logic              st_wr,
    input  logic [ST_W-1:0]   st_wdata,
    output logic [ST_W-1:0]   st_rdata
);
    logic rx_dis_eff;
    logic hit_xon, hit_xoff, hit_spec;
    logic sent_xoff, sent_xon;
    logic txoff, rmt_off, xon_cmd;

    ibfc_rx_watch #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_req  (rx_dis_req),
        .busy     (rx_busy),
        .valid    (rx_valid),
        .char_in  (rx_char),
        .code_xon (xon_char),
        .code_xoff(xoff_char),
        .code_spec(spec_char),
        .dis_eff  (rx_dis_eff),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff),
        .hit_spec (hit_spec),
        .store    (rx_store)
    );

    ibfc_ins_ctl u_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .xoff_trig(xoff_trig),
        .xon_cmd  (xon_cmd),
        .rmt_off  (rmt_off),
        .ack      (ins_ack),
        .req      (ins_req),
        .req_xon  (ins_xon),
        .sent_xoff(sent_xoff),
        .sent_xon (sent_xon)
    );

    ibfc_status u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .hit_xoff (hit_xoff),
        .hit_xon  (hit_xon),
        .hit_spec (hit_spec),
        .sent_xoff(sent_xoff),
        .sent_xon (sent_xon),
        .rd       (st_rd),
        .wr       (st_wr),
        .wdata    (st_wdata),
        .rts_n    (rts_n),
        .dtr_n    (dtr_n),
        .rts_flow (rts_flow),
        .dtr_flow (dtr_flow),
        .loopback (loopback),
        .txf_empty(txf_empty),
        .txs_empty(txs_empty),
        .rdata    (st_rdata),
        .txoff    (txoff),
        .rmt_off  (rmt_off),
        .xon_cmd  (xon_cmd)
    );

    // Local transmitter runs only while no stop code is in force.
    assign tx_gate = !txoff;
endmodule

// File: rtl/ibfc_chk.sv
// Checker for ibfc_unit: temporal properties over its ports and the
// effective receiver-disable state. Attached by the bind at the end.
module ibfc_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic [CHAR_W-1:0] xon_char,
    input logic [CHAR_W-1:0] xoff_char,
    input logic [CHAR_W-1:0] spec_char,
    input logic              rx_valid,
    input logic              rx_busy,
    input logic [CHAR_W-1:0] rx_char,
    input logic              rx_store,
    input logic              rx_dis_eff,
    input logic              ins_req,
    input logic              ins_xon,
    input logic              ins_ack,
    input logic              tx_gate,
    input logic              st_rd,
    input logic [7:0]        st_rdata
);
    // R1
    xoff_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_char == xoff_char && !sw_rst) |=> !tx_gate);

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && !sw_rst) |=> ins_req);

    // R3
    stop_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_xon && ins_ack && !sw_rst) |=> st_rdata[1]);

    // R4
    resume_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && ins_xon && ins_ack && !sw_rst) |=> !st_rdata[1]);

    // R7
    spec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && rx_char == spec_char && !sw_rst) |=> st_rdata[4]);

    // R10
    dis_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dis_eff |-> !rx_store);

    // R11
    dis_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> $stable(rx_dis_eff));

    // R12
    flow_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_char == xon_char || rx_char == xoff_char)) |-> !rx_store);
endmodule

bind ibfc_unit ibfc_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .xon_char  (xon_char),
    .xoff_char (xoff_char),
    .spec_char (spec_char),
    .rx_valid  (rx_valid),
    .rx_busy   (rx_busy),
    .rx_char   (rx_char),
    .rx_store  (rx_store),
    .rx_dis_eff(rx_dis_eff),
    .ins_req   (ins_req),
    .ins_xon   (ins_xon),
    .ins_ack   (ins_ack),
    .tx_gate   (tx_gate),
    .st_rd     (st_rd),
    .st_rdata  (st_rdata)
);

// File: tb/ibfc_unit_tb.sv
`timescale 1ns/1ps
module ibfc_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n, sw_rst;
    logic [7:0] xon_char, xoff_char, spec_char;
    logic       rx_dis_req, rx_busy, rx_valid;
    logic [7:0] rx_char;
    logic       rx_store, xoff_trig, ins_req, ins_xon, ins_ack, tx_gate;
    logic       txf_empty, txs_empty, rts_n, dtr_n, rts_flow, dtr_flow, loopback;
    logic       st_rd, st_wr;
    logic [7:0] st_wdata, st_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ibfc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .xon_char(xon_char), .xoff_char(xoff_char), .spec_char(spec_char),
        .rx_dis_req(rx_dis_req), .rx_busy(rx_busy), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_store(rx_store), .xoff_trig(xoff_trig),
        .ins_req(ins_req), .ins_xon(ins_xon), .ins_ack(ins_ack),
        .tx_gate(tx_gate), .txf_empty(txf_empty), .txs_empty(txs_empty),
        .rts_n(rts_n), .dtr_n(dtr_n), .rts_flow(rts_flow), .dtr_flow(dtr_flow),
        .loopback(loopback), .st_rd(st_rd), .st_wr(st_wr),
        .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    // Vector: {char, expect store, expect bit0 after, expect bit4 after}
    localparam logic [10:0] VEC [6] = '{
        {8'h41, 1'b1, 1'b0, 1'b0},
        {8'h13, 1'b0, 1'b1, 1'b0},
        {8'h2A, 1'b1, 1'b1, 1'b1},
        {8'h42, 1'b1, 1'b1, 1'b1},
        {8'h11, 1'b0, 1'b0, 1'b1},
        {8'h13, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic rx_one(input logic [7:0] c);
        rx_valid = 1'b1; rx_char = c;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 0; sw_rst = 0; xon_char = 8'h11; xoff_char = 8'h13; spec_char = 8'h2A;
        rx_dis_req = 0; rx_busy = 0; rx_valid = 0; rx_char = 0; xoff_trig = 0; ins_ack = 0;
        txf_empty = 1; txs_empty = 1; rts_n = 1; dtr_n = 1; rts_flow = 0; dtr_flow = 0;
        loopback = 0; st_rd = 0; st_wr = 0; st_wdata = 0;
        tick(); tick();
        rst_n = 1; settle();
        // R5 R8 reset state
        chk("R5 reset status", st_rdata, 8'h80);
        chk("R5 reset ins_req", {7'd0, ins_req}, 8'd0);
        chk("R1 reset gate", {7'd0, tx_gate}, 8'd1);

        // Table walk: R1 R7 R12
        for (int i = 0; i < 6; i++) begin
            rx_one(VEC[i][10:3]); settle();
            chk("R12 store", {7'd0, rx_store}, {7'd0, VEC[i][2]});
            tick(); rx_valid = 0; settle();
            chk("R1 bit0", {7'd0, st_rdata[0]}, {7'd0, VEC[i][1]});
            chk("R1 gate", {7'd0, tx_gate}, {7'd0, ~VEC[i][1]});
            chk("R7 bit4", {7'd0, st_rdata[4]}, {7'd0, VEC[i][0]});
        end

        // R7 read clears next cycle
        st_rd = 1; settle();
        chk("R7 read shows flag", {7'd0, st_rdata[4]}, 8'd1);
        tick(); st_rd = 0; settle();
        chk("R7 cleared after read", {7'd0, st_rdata[4]}, 8'd0);
        // R7 set coinciding with read wins
        st_rd = 1; rx_one(8'h2A); tick(); st_rd = 0; rx_valid = 0; settle();
        chk("R7 set beats read", {7'd0, st_rdata[4]}, 8'd1);
        st_rd = 1; tick(); st_rd = 0; settle();

        // R2 write 1 no effect, write 0 clears
        st_wr = 1; st_wdata = 8'hFF; tick(); st_wr = 0; settle();
        chk("R2 write1 keeps", {7'd0, st_rdata[0]}, 8'd1);
        chk("R9 write no ro change", st_rdata, 8'h81);
        st_wr = 1; st_wdata = 8'h00; settle();
        chk("R4 write0 clear bit1 no req", {7'd0, ins_req}, 8'd0);
        tick(); st_wr = 0; settle();
        chk("R4 no req after", {7'd0, ins_req}, 8'd0);
        chk("R2 write0 clears", {7'd0, st_rdata[0]}, 8'd0);
        chk("R2 gate back", {7'd0, tx_gate}, 8'd1);
        // R2 collision: stop code wins
        st_wr = 1; st_wdata = 8'h00; rx_one(8'h13); tick(); st_wr = 0; rx_valid = 0; settle();
        chk("R2 stop beats write", {7'd0, st_rdata[0]}, 8'd1);
        rx_one(8'h11); tick(); rx_valid = 0; settle();
        chk("R1 resume clears", {7'd0, st_rdata[0]}, 8'd0);

        // R3 stop insertion
        xoff_trig = 1; tick(); xoff_trig = 0; settle();
        chk("R3 req", {6'd0, ins_req, ins_xon}, 8'b10);
        tick(); tick(); tick();
        chk("R3 held", {6'd0, ins_req, ins_xon}, 8'b10);
        chk("R3 bit1 before ack", {7'd0, st_rdata[1]}, 8'd0);
        ins_ack = 1; tick(); ins_ack = 0; settle();
        chk("R3 req dropped", {7'd0, ins_req}, 8'd0);
        chk("R3 bit1 set", {7'd0, st_rdata[1]}, 8'd1);
        xoff_trig = 1; tick(); xoff_trig = 0; settle();
        chk("R3 trig ignored while halted", {7'd0, ins_req}, 8'd0);

        // R4 resume insertion
        st_wr = 1; st_wdata = 8'h02; tick(); st_wr = 0; settle();
        chk("R4 write1 no req", {7'd0, ins_req}, 8'd0);
        st_wr = 1; st_wdata = 8'h00; tick(); st_wr = 0; settle();
        chk("R4 resume req", {6'd0, ins_req, ins_xon}, 8'b11);
        chk("R4 bit1 until ack", {7'd0, st_rdata[1]}, 8'd1);
        ins_ack = 1; tick(); ins_ack = 0; settle();
        chk("R4 bit1 cleared", {7'd0, st_rdata[1]}, 8'd0);
        chk("R4 req dropped", {7'd0, ins_req}, 8'd0);

        // R5 channel reset clears sticky bits and pending request
        xoff_trig = 1; tick(); xoff_trig = 0; ins_ack = 1; tick(); ins_ack = 0;
        rx_one(8'h2A); tick(); rx_one(8'h13); tick(); rx_valid = 0;
        st_wr = 1; st_wdata = 8'h00; tick(); st_wr = 0; settle();
        chk("R5 pre sticky", st_rdata & 8'h13, 8'h12);
        chk("R5 pre req", {7'd0, ins_req}, 8'd1);
        sw_rst = 1; tick(); sw_rst = 0; settle();
        chk("R5 sw reset bits", st_rdata & 8'h13, 8'h00);
        chk("R5 sw reset req", {7'd0, ins_req}, 8'd0);

        // R6 modem view
        rts_n = 0; dtr_n = 1; settle();
        chk("R6 normal", st_rdata & 8'h0C, 8'h04);
        loopback = 1; rts_flow = 0; dtr_flow = 1; settle();
        chk("R6 loopback", st_rdata & 8'h0C, 8'h08);
        loopback = 0; rts_n = 1;

        // R8 R9 idle and reserved bits
        txs_empty = 0; settle();
        chk("R8 busy shift", {7'd0, st_rdata[7]}, 8'd0);
        txs_empty = 1; txf_empty = 0; settle();
        chk("R8 busy fifo", {7'd0, st_rdata[7]}, 8'd0);
        txf_empty = 1; settle();
        chk("R8 idle", {7'd0, st_rdata[7]}, 8'd1);
        st_wr = 1; st_wdata = 8'h7C; tick(); st_wr = 0; settle();
        chk("R9 reserved zero", st_rdata, 8'h80);

        // R10 R11 receiver disable at boundary
        rx_busy = 1; rx_dis_req = 1; tick();
        rx_one(8'h41); settle();
        chk("R11 old setting", {7'd0, rx_store}, 8'd1);
        tick(); rx_valid = 0; rx_busy = 0; tick();
        rx_one(8'h2A); settle();
        chk("R10 no store", {7'd0, rx_store}, 8'd0);
        tick(); rx_valid = 0; settle();
        chk("R10 no special", {7'd0, st_rdata[4]}, 8'd0);
        rx_one(8'h13); tick(); rx_valid = 0; settle();
        chk("R10 stop acted", {7'd0, st_rdata[0]}, 8'd1);
        rx_one(8'h11); tick(); rx_valid = 0; settle();
        chk("R10 resume acted", {7'd0, st_rdata[0]}, 8'd0);
        rx_dis_req = 0; rx_busy = 1; tick();
        rx_one(8'h41); settle();
        chk("R11 still disabled", {7'd0, rx_store}, 8'd0);
        tick(); rx_valid = 0; rx_busy = 0; tick();
        rx_one(8'h41); settle();
        chk("R11 enabled", {7'd0, rx_store}, 8'd1);
        tick(); rx_valid = 0;

        // R5 hardware reset
        rx_one(8'h13); tick(); rx_valid = 0;
        rst_n = 0; tick(); rst_n = 1; settle();
        chk("R5 hw reset", st_rdata, 8'h80);

        done = 1'b1;
        summary();
    end
endmodule